// File: doc/BRIEF.md
# Word-Wide Bit-Clearing EPROM Model

This block is a synthesizable, clock-based stand-in for a 16-bit-wide erasable programmable read-only memory. It can serve as a target in a testbench or on an emulation board. The storage array is scaled down, and its depth is a parameter. The full 18-bit word address is still accepted, and any address bits above the array depth are ignored. The pins it models are as follows. Chip select and output gate are both active low. A flag says the high programming supply is present, and a second flag says the identifier level is applied to address line 9. All pins are sampled on the clock. The data output comes from a register, together with a drive indication that stands in for the tri-state enable.

Programming can only clear bits. A program pulse is a low phase of chip select while the programming flag is set and the output gate is high. The pulse ANDs the captured input word into the stored word when chip select returns high. A separate identifier mode returns one of two fixed codes, chosen by address bit 0. An erase input, and reset, put every word back to all ones.

Top module: `wweprom_model`

## Requirements
- R1: Reset and the erase input both set every stored word to 16'hFFFF. While reset is active, the output is undriven (dout_en=0, dout=0).
- R2: Read mode is ce_n=0, oe_n=0, prog_en=0 and id_en=0. Its inputs are sampled at one clock edge, and from that edge dout_en=1 and dout holds the word at addr modulo DEPTH. Address bits at and above log2(DEPTH) have no effect.
- R3: With ce_n=1 the output is undriven at the next edge. This covers standby and program inhibit. The only exception is the verify case of R7.
- R4: With ce_n=0 and oe_n=1 the output is undriven at the next edge. Whenever dout_en=0, dout is 0.
- R5: A committed program operation replaces the stored word with the old word AND the input word. No bit ever changes from 0 to 1 except by erase or reset.
- R6: A write commits at the first clock edge that sees ce_n=1 after one or more edges that saw ce_n=0, prog_en=1 and oe_n=1. prog_en=1 and oe_n=1 must still hold at that edge. The address and data used are those sampled at the last low edge. If prog_en or oe_n changes before chip select rises, no word changes.
- R7: Verify mode is prog_en=1, ce_n=1 and oe_n=0. It drives the stored word at addr at the next edge.
- R8: Identifier mode is ce_n=0, oe_n=0, prog_en=0 and id_en=1. It drives 16'h0020 when addr[0]=0 and 16'h0044 when addr[0]=1.
- R9: A single pulse writes exactly once, however many cycles chip select stays low.
- R10: With prog_en=1 and both ce_n and oe_n low, the output is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 18 | Word address |
| ce_n | input | 1 | Chip select, active low; its rising edge ends a program pulse |
| oe_n | input | 1 | Output gate, active low |
| din | input | 16 | Word to program |
| prog_en | input | 1 | Programming supply present |
| id_en | input | 1 | Identifier level on address line 9 |
| erase | input | 1 | Sets every word to all ones |
| dout | output | 16 | Output word, 0 when undriven |
| dout_en | output | 1 | Output drive indication |

## Verification
A wrong stored word stays hidden until that address is read or verified. For this reason the bench reads back through read and verify modes against a reference array after every pulse, and it sweeps words after an erase. A wrong mode decode or a lost drive indication shows at the output one edge after the inputs are applied. A commit that is doubled, lost or misaddressed only appears as a stored value, on the next read of the affected word. Missing a 0-to-1 change in particular needs a later pulse with new ones in its data.

// File: rtl/wweprom_pkg.sv
package wweprom_pkg;

  typedef enum logic [2:0] {
    MD_OFF    = 3'd0,
    MD_READ   = 3'd1,
    MD_VERIFY = 3'd2,
    MD_IDENT  = 3'd3,
    MD_PULSE  = 3'd4
  } mode_e;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned CODE_W = 8;

endpackage

// File: rtl/wweprom_mode_dec.sv
module wweprom_mode_dec
  import wweprom_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  prog_en,
  input  logic  id_en,
  output mode_e mode
);

  always_comb begin
    mode = MD_OFF;
    if (ce_n) begin
      if (prog_en && !oe_n) mode = MD_VERIFY;
    end else if (oe_n) begin
      if (prog_en) mode = MD_PULSE;
    end else if (!prog_en) begin
      mode = id_en ? MD_IDENT : MD_READ;
    end
  end

endmodule

// File: rtl/wweprom_pulse_ctl.sv
module wweprom_pulse_ctl #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          prog_en,
  input  logic [AW-1:0] addr_idx,
  input  logic [DW-1:0] din,
  output logic          commit,
  output logic [AW-1:0] wr_idx,
  output logic [DW-1:0] wr_data
);

  logic          armed_q, armed_d;
  logic [AW-1:0] cap_idx_q, cap_idx_d;
  logic [DW-1:0] cap_dat_q, cap_dat_d;
  logic          low_phase;

  assign low_phase = prog_en && oe_n && !ce_n;

  always_comb begin
    armed_d   = low_phase;
    cap_idx_d = cap_idx_q;
    cap_dat_d = cap_dat_q;
    if (low_phase) begin
      cap_idx_d = addr_idx;
      cap_dat_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      cap_idx_q <= '0;
      cap_dat_q <= '0;
    end else begin
      armed_q   <= armed_d;
      cap_idx_q <= cap_idx_d;
      cap_dat_q <= cap_dat_d;
    end
  end

  assign commit  = armed_q && ce_n && prog_en && oe_n;
  assign wr_idx  = cap_idx_q;
  assign wr_data = cap_dat_q;

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R9

  AST_COMMIT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(!ce_n && prog_en && oe_n)); // R6

endmodule

// File: rtl/wweprom_array.sv
module wweprom_array #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);

  localparam logic [DW-1:0] BLANK = {DW{1'b1}};

  logic [DW-1:0] cells [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    logic          hit;
    logic [DW-1:0] nxt;

    assign hit = wr_en && (wr_idx == AW'(gi));

    always_comb begin
      nxt = cells[gi];
      if (erase)    nxt = BLANK;
      else if (hit) nxt = cells[gi] & wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cells[gi] <= BLANK;
      else if (erase || hit)  cells[gi] <= nxt;
    end

    AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !erase |=> ((cells[gi] & ~$past(cells[gi])) == '0)); // R5
  end

  assign rd_data = cells[rd_idx];

  AST_ERASE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (cells[0] == BLANK && cells[DEPTH-1] == BLANK)); // R1

endmodule

// File: rtl/wweprom_model.sv
module wweprom_model
  import wweprom_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DEPTH    = 1024,
  parameter logic [7:0]  MFR_CODE = 8'h20,
  parameter logic [7:0]  DEV_CODE = 8'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [15:0]       din,
  input  logic              prog_en,
  input  logic              id_en,
  input  logic              erase,
  output logic [15:0]       dout,
  output logic              dout_en
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned DW = WORD_W;

  mode_e         mode;
  logic [AW-1:0] idx;
  logic          commit;
  logic [AW-1:0] wr_idx;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] ident_word;
  logic [DW-1:0] dout_d;
  logic          den_d;

  assign idx = addr[AW-1:0];

  if (ADDR_W > AW) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^addr[ADDR_W-1:AW];
  end

  wweprom_mode_dec u_dec (
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .prog_en (prog_en),
    .id_en   (id_en),
    .mode    (mode)
  );

  wweprom_pulse_ctl #(.AW(AW), .DW(DW)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .prog_en  (prog_en),
    .addr_idx (idx),
    .din      (din),
    .commit   (commit),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  wweprom_array #(.DEPTH(DEPTH), .DW(DW)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .erase   (erase),
    .wr_en   (commit),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (idx),
    .rd_data (rd_data)
  );

  assign ident_word = {{(DW-CODE_W){1'b0}}, (addr[0] ? DEV_CODE : MFR_CODE)};

  always_comb begin
    den_d  = 1'b0;
    dout_d = '0;
    unique case (mode)
      MD_READ, MD_VERIFY: begin
        den_d  = 1'b1;
        dout_d = rd_data;
      end
      MD_IDENT: begin
        den_d  = 1'b1;
        dout_d = ident_word;
      end
      default: begin
        den_d  = 1'b0;
        dout_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout    <= dout_d;
      dout_en <= den_d;
    end
  end

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !(prog_en && !oe_n)) |=> !dout_en); // R3

  AST_GATE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |=> (!dout_en && dout == '0)); // R4

  AST_VERIFY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && ce_n && !oe_n) |=> dout_en); // R7

  AST_IDENT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !prog_en && id_en) |=> (dout_en && dout[15:8] == 8'h00)); // R8

  AST_CONFLICT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && prog_en) |=> !dout_en); // R10

endmodule

// File: tb/tb_wweprom_model.sv
`timescale 1ns/1ps
module tb_wweprom_model;

  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [17:0] addr;
  logic        ce_n, oe_n, prog_en, id_en, erase;
  logic [15:0] din;
  logic [15:0] dout;
  logic        dout_en;

  int checks = 0;
  int errors = 0;
  logic [15:0] ref_mem [DEPTH];

  always #2.5 clk = ~clk;

  wweprom_model dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .din(din), .prog_en(prog_en), .id_en(id_en), .erase(erase),
    .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [15:0] exp_ident(input logic a0);
    return a0 ? 16'h0044 : 16'h0020;
  endfunction

  function automatic int widx(input logic [17:0] a);
    return int'(a) % DEPTH;
  endfunction

  task automatic check(input string req, input logic en_exp, input logic [15:0] d_exp);
    checks++;
    if (dout_en !== en_exp || dout !== d_exp) begin
      errors++;
      $display("FAIL %s: got en=%0b data=%04h, expected en=%0b data=%04h",
               req, dout_en, dout, en_exp, d_exp);
    end
  endtask

  task automatic idle_pins();
    ce_n = 1'b1; oe_n = 1'b1; prog_en = 1'b0; id_en = 1'b0; erase = 1'b0;
  endtask

  task automatic do_read(input logic [17:0] a, input string req);
    @(negedge clk);
    idle_pins(); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    check(req, 1'b1, ref_mem[widx(a)]);
  endtask

  task automatic do_verify(input logic [17:0] a);
    @(negedge clk);
    idle_pins(); addr = a; prog_en = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    check("R7 verify", 1'b1, ref_mem[widx(a)]);
  endtask

  task automatic do_ident(input logic a0);
    @(negedge clk);
    idle_pins(); addr = {17'd0, a0}; id_en = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    check("R8 identifier", 1'b1, exp_ident(a0));
  endtask

  task automatic do_program(input logic [17:0] a, input logic [15:0] d, input int len);
    @(negedge clk);
    idle_pins(); prog_en = 1'b1; addr = a; din = d;
    @(negedge clk);
    ce_n = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      check("R4 hi-Z during pulse", 1'b0, 16'h0000);
    end
    ce_n = 1'b1;
    addr = ~a; din = 16'h0000;
    @(negedge clk);
    check("R3 inhibit hi-Z", 1'b0, 16'h0000);
    ref_mem[widx(a)] = ref_mem[widx(a)] & d;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    logic [17:0] a;
    seed = 32'h1D5;
    void'($urandom(seed));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'hFFFF;
    idle_pins(); addr = '0; din = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset output off", 1'b0, 16'h0000);
    rst_n = 1'b1;
    do_read(18'd0, "R1 blank after reset");
    do_read(18'd1023, "R1 blank after reset");

    // standby with output gate low, and output disable
    @(negedge clk); idle_pins(); oe_n = 1'b0;
    @(negedge clk); check("R3 standby", 1'b0, 16'h0000);
    @(negedge clk); idle_pins(); ce_n = 1'b0;
    @(negedge clk); check("R4 output disable", 1'b0, 16'h0000);

    do_ident(1'b0);
    do_ident(1'b1);

    // bit clearing: second pulse may not set bits back
    do_program(18'd5, 16'hF0F0, 1);
    do_read(18'd5, "R5 first program");
    do_program(18'd5, 16'h0FFF, 2);
    do_read(18'd5, "R5 AND with old word");
    do_verify(18'd5);

    // long pulse writes once; upper address bits ignored
    do_program(18'h3_0007, 16'hAAAA, 9);
    do_read(18'd7, "R9 long pulse");
    do_read(18'h2_0407, "R2 upper bits ignored");

    // aborted pulse: programming flag drops while chip select low
    @(negedge clk); idle_pins(); prog_en = 1'b1; addr = 18'd9; din = 16'h0000;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); prog_en = 1'b0;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
    do_read(18'd9, "R6 aborted pulse");

    // aborted pulse: output gate drops while chip select low
    @(negedge clk); idle_pins(); prog_en = 1'b1; addr = 18'd10; din = 16'h0000;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); oe_n = 1'b0;
    @(negedge clk); check("R10 conflict hi-Z", 1'b0, 16'h0000);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    do_read(18'd10, "R6 gate abort");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      a  = 18'($urandom_range(0, 262143));
      if (n % 3 == 0) a = {a[17:4], 4'd3};
      case (op)
        0, 1, 2: do_program(a, 16'($urandom()), int'($urandom_range(1, 4)));
        3, 4, 5: do_read(a, "R2 random read");
        6, 7:    do_verify(a);
        8:       do_ident(a[0]);
        default: begin
          @(negedge clk); idle_pins(); oe_n = 1'b0; ce_n = 1'($urandom_range(0, 1));
          @(negedge clk);
          if (ce_n) check("R3 random standby", 1'b0, 16'h0000);
          else      do_read(a, "R2 random read");
        end
      endcase
    end

    // erase returns all ones
    @(negedge clk); idle_pins(); erase = 1'b1;
    @(negedge clk); erase = 1'b0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'hFFFF;
    do_read(18'd3, "R1 erase");
    do_read(18'd5, "R1 erase");
    do_read(18'd1023, "R1 erase");

    @(negedge clk); idle_pins();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule